// File: doc/BRIEF.md
# Multi-Plane Video Pixel Serializer

This block sits between the serial port of a dual-port video memory and the monitor outputs. Once per memory cycle it takes one memory word, of which only the even-numbered bits carry pixel data. It cuts the word into logical pixels of one, two or four bitplanes and sends one logical pixel per dot clock on four plane outputs. Plane outputs that the selected mode does not use stay low.

A line starts with a load pulse. The load captures the first word and latches the plane mode, the zoom code and the pan offset for the whole line. The pan offset picks the logical pixel inside that first word where display begins. The zoom code repeats every logical pixel for one, two or four dot clocks. A blank input darkens the outputs and freezes the shifter. A blink control forces to black any pixel whose scratch plane is set while the blink is in its off phase.

Each time the block consumes a word it raises a word-advance strobe in the same cycle. The memory side must then present the next word before the following clock edge.

Top module: `vid_plane_serializer`

## Requirements
- R1: While `rst` is high, `ser_adv` is low. In the cycle after a reset edge, `planes` is 4'b0000.
- R2: A cycle with `line_load` high captures `word_in` and latches `mode_sel`, `zoom_code` and `pan_in` for the line. Changes to those three inputs between loads have no effect. `ser_adv` is high in the load cycle, and `planes` is 4'b0000 in the cycle after the load edge.
- R3: Only the even bits of `word_in` are used. Bit 2i becomes packed bit p[i], for i = 0..7. Logical pixels are taken from the low end of p upward.
- R4: Four-plane mode (`mode_sel` 2 or 3) gives two pixels per word. Pixel k drives `planes[3:0]` = p[4k+3:4k], and the scratch plane is `planes[3]`.
- R5: Two-plane mode (`mode_sel` 1) gives four pixels per word. Pixel k drives `planes[1:0]` = p[2k+1:2k], `planes[3:2]` stays 0, and the scratch plane is `planes[1]`.
- R6: One-plane mode (`mode_sel` 0) gives eight pixels per word. Pixel k drives `planes[0]` = p[k], `planes[3:1]` stays 0, and the scratch plane is `planes[0]`.
- R7: Zoom codes 4'b0000, 4'b0001 and 4'b0011 hold each logical pixel for 1, 2 and 4 displayed dot clocks. Every other code holds it for 1.
- R8: The first pixel shown after a load has index `pan_in` modulo the pixels per word: one pan bit is used in four-plane mode, two in two-plane mode and three in one-plane mode. The other pan bits are ignored. Every later word starts at pixel 0.
- R9: `ser_adv` is high, with no load present, exactly in the displayed cycle that shows the last repeat of a word's last pixel. The next word is captured at that edge.
- R10: A cycle with `blank` high and no load gives `planes` = 0 in the next cycle. It also keeps the shifter position and `ser_adv` low.
- R11: With `blink_en` high and `blink_on` low, a pixel whose scratch-plane bit is set is output as 4'b0000. In every other case the pixel passes unchanged.
- R12: `planes` is registered. A pixel selected in a displayed cycle appears in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| line_load | input | 1 | Start of line: capture first word and latch line settings |
| blank | input | 1 | Blanking interval: outputs dark, shifter frozen |
| word_in | input | WORD_W | Memory serial-port word; even bits carry pixel data |
| mode_sel | input | 2 | Plane mode: 0 one plane, 1 two planes, 2/3 four planes |
| zoom_code | input | 4 | Horizontal zoom code |
| pan_in | input | PAN_W | Start-pixel offset within the first word |
| blink_en | input | 1 | Enable scratch-plane blinking |
| blink_on | input | 1 | Blink phase: high visible, low off |
| ser_adv | output | 1 | Word consumed this cycle; present next word by next edge |
| planes | output | 4 | Registered bitplane outputs for the current dot |

## Verification
The main path is driven with random words in every plane mode and with each valid zoom code as well as an invalid one. With no blanking, these runs show the bit order within a word and the pixel repeat count. Odd pan values with set upper bits separate correct pan masking from using the full pan field. Periodic blanking inside a line shows whether the shifter holds its position rather than losing pixels. Reloads in the middle of a line, with the settings changed right after each load, show whether the settings were latched. Blink phases toggling over words with random scratch bits separate gating of the scratch plane from gating of the whole output.

// File: rtl/vps_pkg.sv
package vps_pkg;

  typedef enum logic [1:0] {
    PM_ONE  = 2'd0,
    PM_TWO  = 2'd1,
    PM_FOUR = 2'd2
  } plane_mode_e;

  localparam int NPLANE = 4;
  localparam int ZCODE_W = 4;

  function automatic plane_mode_e mode_decode(input logic [1:0] code);
    case (code)
      2'd0:    return PM_ONE;
      2'd1:    return PM_TWO;
      default: return PM_FOUR;
    endcase
  endfunction

  // last repeat index of a logical pixel (factor minus one)
  function automatic logic [1:0] zoom_last(input logic [ZCODE_W-1:0] code);
    case (code)
      4'b0000: return 2'd0;
      4'b0001: return 2'd1;
      4'b0011: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  // log2 of bits per logical pixel
  function automatic logic [1:0] mode_shift(input plane_mode_e m);
    case (m)
      PM_ONE:  return 2'd0;
      PM_TWO:  return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/vps_cfg.sv
module vps_cfg
  import vps_pkg::*;
#(
  parameter int PIX_W = 3,
  parameter int PAN_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                line_load,
  input  logic [1:0]          mode_sel,
  input  logic [ZCODE_W-1:0]  zoom_code,
  input  logic [PAN_W-1:0]    pan_in,
  output plane_mode_e         mode_q,
  output logic [1:0]          rep_max_q,
  output logic [PIX_W-1:0]    pix_max_q,
  output logic [PIX_W-1:0]    start_pix
);

  plane_mode_e      mode_live;
  logic [PIX_W-1:0] pix_max_live;
  logic             unused_pan_hi;

  assign mode_live    = mode_decode(mode_sel);
  assign pix_max_live = {PIX_W{1'b1}} >> mode_shift(mode_live);
  assign start_pix    = pan_in[PIX_W-1:0] & pix_max_live;

  generate
    if (PAN_W > PIX_W) begin : g_pan_hi
      assign unused_pan_hi = ^pan_in[PAN_W-1:PIX_W];
    end else begin : g_pan_fit
      assign unused_pan_hi = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= PM_ONE;
      rep_max_q <= 2'd0;
      pix_max_q <= '0;
    end else if (line_load) begin
      mode_q    <= mode_live;
      rep_max_q <= zoom_last(zoom_code);
      pix_max_q <= pix_max_live;
    end
  end

endmodule

// File: rtl/vps_seq.sv
module vps_seq #(
  parameter int UB    = 8,
  parameter int PIX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_load,
  input  logic              blank,
  input  logic [2*UB-1:0]   word_in,
  input  logic [PIX_W-1:0]  pix_max,
  input  logic [1:0]        rep_max,
  input  logic [PIX_W-1:0]  start_pix,
  output logic [UB-1:0]     word_q,
  output logic [PIX_W-1:0]  pix_q,
  output logic              show,
  output logic              ser_adv
);

  logic [UB-1:0] packed_w;
  logic [UB-1:0] odd_bits;
  logic          unused_odd;
  logic [1:0]    rep_q;
  logic          active_q;
  logic          rep_last;
  logic          pix_last;
  logic          word_done;

  generate
    for (genvar i = 0; i < UB; i++) begin : g_pack
      assign packed_w[i] = word_in[2*i];
      assign odd_bits[i] = word_in[2*i+1];
    end
  endgenerate
  assign unused_odd = ^odd_bits;

  assign show      = active_q & ~blank & ~line_load;
  assign rep_last  = (rep_q == rep_max);
  assign pix_last  = (pix_q == pix_max);
  assign word_done = show & rep_last & pix_last;
  assign ser_adv   = ~rst & (line_load | word_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      word_q   <= '0;
      pix_q    <= '0;
      rep_q    <= 2'd0;
    end else if (line_load) begin
      active_q <= 1'b1;
      word_q   <= packed_w;
      pix_q    <= start_pix;
      rep_q    <= 2'd0;
    end else if (show) begin
      if (rep_last) begin
        rep_q <= 2'd0;
        if (pix_last) begin
          pix_q  <= '0;
          word_q <= packed_w;
        end else begin
          pix_q <= pix_q + 1'b1;
        end
      end else begin
        rep_q <= rep_q + 2'd1;
      end
    end
  end

endmodule

// File: rtl/vps_pixsel.sv
module vps_pixsel
  import vps_pkg::*;
#(
  parameter int UB    = 8,
  parameter int PIX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              show,
  input  plane_mode_e       mode,
  input  logic [UB-1:0]     word_q,
  input  logic [PIX_W-1:0]  pix_q,
  input  logic              blink_en,
  input  logic              blink_on,
  output logic [NPLANE-1:0] planes
);

  logic [PIX_W+1:0]  amt;
  logic [UB-1:0]     sh;
  logic [NPLANE-1:0] val;
  logic              scratch;
  logic              dark;

  always_comb begin
    amt = {2'b00, pix_q} << mode_shift(mode);
    sh  = word_q >> amt;
    case (mode)
      PM_FOUR: begin val = sh[3:0];          scratch = sh[3]; end
      PM_TWO:  begin val = {2'b00, sh[1:0]}; scratch = sh[1]; end
      default: begin val = {3'b000, sh[0]};  scratch = sh[0]; end
    endcase
    dark = blink_en & ~blink_on & scratch;
  end

  always_ff @(posedge clk) begin
    if (rst)             planes <= '0;
    else if (show && !dark) planes <= val;
    else                 planes <= '0;
  end

endmodule

// File: rtl/vid_plane_serializer.sv
module vid_plane_serializer
  import vps_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int PAN_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                line_load,
  input  logic                blank,
  input  logic [WORD_W-1:0]   word_in,
  input  logic [1:0]          mode_sel,
  input  logic [3:0]          zoom_code,
  input  logic [PAN_W-1:0]    pan_in,
  input  logic                blink_en,
  input  logic                blink_on,
  output logic                ser_adv,
  output logic [3:0]          planes
);

  localparam int UB    = WORD_W / 2;
  localparam int PIX_W = $clog2(UB);

  plane_mode_e      mode_q;
  logic [1:0]       rep_max;
  logic [PIX_W-1:0] pix_max;
  logic [PIX_W-1:0] start_pix;
  logic [UB-1:0]    word_q;
  logic [PIX_W-1:0] pix_q;
  logic             show;

  vps_cfg #(.PIX_W(PIX_W), .PAN_W(PAN_W)) u_cfg (
    .clk(clk), .rst(rst), .line_load(line_load),
    .mode_sel(mode_sel), .zoom_code(zoom_code), .pan_in(pan_in),
    .mode_q(mode_q), .rep_max_q(rep_max), .pix_max_q(pix_max),
    .start_pix(start_pix)
  );

  vps_seq #(.UB(UB), .PIX_W(PIX_W)) u_seq (
    .clk(clk), .rst(rst), .line_load(line_load), .blank(blank),
    .word_in(word_in), .pix_max(pix_max), .rep_max(rep_max),
    .start_pix(start_pix), .word_q(word_q), .pix_q(pix_q),
    .show(show), .ser_adv(ser_adv)
  );

  vps_pixsel #(.UB(UB), .PIX_W(PIX_W)) u_pix (
    .clk(clk), .rst(rst), .show(show), .mode(mode_q),
    .word_q(word_q), .pix_q(pix_q), .blink_en(blink_en),
    .blink_on(blink_on), .planes(planes)
  );

endmodule

// File: rtl/vps_checker.sv
module vps_checker
  import vps_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        line_load,
  input logic        blank,
  input logic        blink_en,
  input logic        blink_on,
  input logic        ser_adv,
  input logic [3:0]  planes,
  input plane_mode_e mode_q,
  input logic [1:0]  rep_max
);

  a_r1_reset_dark: assert property (@(posedge clk) rst |=> planes == 4'b0000);
  a_r1_reset_no_adv: assert property (@(posedge clk) rst |-> !ser_adv);

  a_r2_load_adv: assert property (@(posedge clk) disable iff (rst)
    line_load |-> ser_adv);
  a_r2_load_dark: assert property (@(posedge clk) disable iff (rst)
    line_load |=> planes == 4'b0000);

  a_r10_blank_dark: assert property (@(posedge clk) disable iff (rst)
    blank |=> planes == 4'b0000);
  a_r10_blank_no_adv: assert property (@(posedge clk) disable iff (rst)
    (blank && !line_load) |-> !ser_adv);

  a_r5_two_unused: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_TWO) |=> planes[3:2] == 2'b00);
  a_r6_one_unused: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_ONE) |=> planes[3:1] == 3'b000);

  a_r11_blink_four: assert property (@(posedge clk) disable iff (rst)
    (blink_en && !blink_on && mode_q == PM_FOUR) |=> !planes[3]);
  a_r11_blink_two: assert property (@(posedge clk) disable iff (rst)
    (blink_en && !blink_on && mode_q == PM_TWO) |=> !planes[1]);
  a_r11_blink_one: assert property (@(posedge clk) disable iff (rst)
    (blink_en && !blink_on && mode_q == PM_ONE) |=> !planes[0]);

  // R7: with zoom above 1 a word advance is never followed by another displayed advance
  a_r7_zoom_spacing: assert property (@(posedge clk) disable iff (rst)
    (ser_adv && !line_load && rep_max != 2'd0) |=> (line_load || !ser_adv));

endmodule

bind vid_plane_serializer vps_checker u_chk (
  .clk(clk), .rst(rst), .line_load(line_load), .blank(blank),
  .blink_en(blink_en), .blink_on(blink_on), .ser_adv(ser_adv),
  .planes(planes), .mode_q(mode_q), .rep_max(rep_max)
);

// File: tb/tb_vid_plane_serializer.sv
module tb_vid_plane_serializer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_load = 1'b0;
  logic        blank = 1'b1;
  logic [15:0] word_in = '0;
  logic [1:0]  mode_sel = 2'd0;
  logic [3:0]  zoom_code = 4'd0;
  logic [3:0]  pan_in = 4'd0;
  logic        blink_en = 1'b0;
  logic        blink_on = 1'b1;
  logic        ser_adv;
  logic [3:0]  planes;

  vid_plane_serializer dut (
    .clk(clk), .rst(rst), .line_load(line_load), .blank(blank),
    .word_in(word_in), .mode_sel(mode_sel), .zoom_code(zoom_code),
    .pan_in(pan_in), .blink_en(blink_en), .blink_on(blink_on),
    .ser_adv(ser_adv), .planes(planes)
  );

  always #5 clk = ~clk;

  // reference state
  logic [15:0] mem [256];
  int    ptr = 0;
  int    m_active = 0, m_bpp = 1, m_zf = 1, m_pix = 0, m_rep = 0;
  int    m_word = 0;
  int    exp_planes = 0;
  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  string tag = "R1";

  function automatic int pack_even(input logic [15:0] w);
    int r = 0;
    for (int i = 0; i < 8; i++) if (w[2*i]) r |= (1 << i);
    return r;
  endfunction

  function automatic int zoom_factor(input logic [3:0] c);
    if (c == 4'b0000) return 1;
    if (c == 4'b0001) return 2;
    if (c == 4'b0011) return 4;
    return 1;
  endfunction

  function automatic int pixel_value();
    int v, s;
    v = (m_word >> (m_pix * m_bpp)) & ((1 << m_bpp) - 1);
    s = (v >> (m_bpp - 1)) & 1;
    if (blink_en && !blink_on && s == 1) return 0;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_active = 0; exp_planes = 0; ptr = 0; m_pix = 0; m_rep = 0;
    end else if (line_load) begin
      m_bpp    = (mode_sel == 2'd0) ? 1 : ((mode_sel == 2'd1) ? 2 : 4);
      m_zf     = zoom_factor(zoom_code);
      m_word   = pack_even(mem[ptr]);
      ptr      = (ptr + 1) % 256;
      m_pix    = pan_in % (8 / m_bpp);
      m_rep    = 0;
      m_active = 1;
      exp_planes = 0;
    end else if (blank || m_active == 0) begin
      exp_planes = 0;
    end else begin
      exp_planes = pixel_value();
      m_rep++;
      if (m_rep == m_zf) begin
        m_rep = 0;
        m_pix++;
        if (m_pix == 8 / m_bpp) begin
          m_pix  = 0;
          m_word = pack_even(mem[ptr]);
          ptr    = (ptr + 1) % 256;
        end
      end
    end
  end

  task automatic check(input string t, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic step(input bit ld, input bit blk);
    int ea;
    @(negedge clk);
    check({tag, " planes"}, int'(planes), exp_planes);
    line_load = ld;
    blank     = blk;
    word_in   = mem[ptr];
    #1;
    ea = (!rst && (ld || (m_active == 1 && !blk && m_rep == m_zf - 1 &&
                          m_pix == 8 / m_bpp - 1))) ? 1 : 0;
    check({tag, " ser_adv"}, int'(ser_adv), ea);
  endtask

  task automatic run_line(input logic [1:0] md, input logic [3:0] zc,
                          input logic [3:0] pn, input int n);
    mode_sel = md; zoom_code = zc; pan_in = pn;
    step(1'b1, 1'b0);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    // R1: reset state
    tag = "R1";
    rst = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    // R4 / R3 / R12: four-plane, no zoom
    tag = "R4";  run_line(2'd2, 4'b0000, 4'd0, 40);
    // R5: two-plane, zoom 2, pan with upper bit set
    tag = "R5";  run_line(2'd1, 4'b0001, 4'b0110, 40);
    // R6 / R8: one-plane, zoom 4, pan 13 -> pixel 5
    tag = "R6";  run_line(2'd0, 4'b0011, 4'd13, 60);
    // R7: invalid zoom code acts as 1, mode 3 acts as four-plane
    tag = "R7";  run_line(2'd3, 4'b0101, 4'd1, 30);
    tag = "R7";  run_line(2'd1, 4'b1111, 4'd0, 30);
    // R8: four-plane pan 3 -> pixel 1
    tag = "R8";  run_line(2'd2, 4'b0001, 4'd3, 30);
    // R9: long line, word advances across many words
    tag = "R9";  run_line(2'd2, 4'b0001, 4'd0, 80);
    // R10: blanking pulses inside the line
    tag = "R10";
    mode_sel = 2'd1; zoom_code = 4'b0000; pan_in = 4'd1;
    step(1'b1, 1'b0);
    for (int i = 0; i < 70; i++) step(1'b0, (i % 7) < 2);
    // R11: blinking in four- and one-plane modes
    tag = "R11";
    blink_en = 1'b1;
    mode_sel = 2'd2; zoom_code = 4'b0000; pan_in = 4'd0;
    step(1'b1, 1'b0);
    for (int i = 0; i < 60; i++) begin blink_on = ((i / 5) % 2) == 0; step(1'b0, 1'b0); end
    mode_sel = 2'd0;
    step(1'b1, 1'b0);
    for (int i = 0; i < 40; i++) begin blink_on = ((i / 3) % 2) == 0; step(1'b0, 1'b0); end
    blink_en = 1'b0; blink_on = 1'b0;
    tag = "R11"; run_line(2'd1, 4'b0000, 4'd0, 20);
    blink_on = 1'b1;
    // R2: reloads mid-line, settings changed after each load
    tag = "R2";
    for (int k = 0; k < 5; k++) begin
      mode_sel = 2'(k % 3); zoom_code = (k % 2) ? 4'b0001 : 4'b0011; pan_in = 4'(k * 3);
      step(1'b1, 1'b0);
      mode_sel = 2'(~mode_sel); zoom_code = 4'b0000; pan_in = 4'd0;
      for (int i = 0; i < 9; i++) step(1'b0, (i == 4));
    end
    // R3: mixed random lines
    tag = "R3";
    for (int k = 0; k < 8; k++) begin
      mode_sel = 2'($urandom_range(0, 3));
      zoom_code = 4'($urandom_range(0, 3));
      pan_in = 4'($urandom);
      step(1'b1, 1'b0);
      for (int i = 0; i < 50; i++) step(1'b0, ($urandom_range(0, 9) == 0));
    end
    step(1'b0, 1'b1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule